// File: doc/BRIEF.md
# Oversampling Serial Receiver with Centre-Sample Voting

This block turns a single asynchronous serial line into received characters. An external rate generator supplies a one-clock enable, `os_tick`, at 16 times the bit rate. In double-speed mode the same enable runs at 8 times the bit rate. The line passes through a two-flop synchroniser and is then looked at only on those ticks. A high-to-low step on the line opens a candidate start bit. Each bit of the frame is then decided by a 2-of-3 vote over the three samples in the middle of the bit. The frame consists of the start bit, 5 to 9 data bits sent least significant first, an optional parity bit and the first stop bit.

The start bit goes through the same vote as the other bits. A short low pulse that loses the vote is dropped, and the receiver waits for a fresh falling edge. The sample counter is reloaded at every accepted start bit, so no timing is carried from one frame to the next. The receiver leaves the frame as soon as the stop bit's last voting sample has been taken. A following start edge can therefore be caught before the stop bit has run to its nominal end.

A one-clock strobe presents each result: the data word, the raw parity bit and a frame error flag. Checking the parity, buffering and generating the rate are left to the surrounding logic.

Top module: `uart_vote_rx`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `rx_valid`, `frame_err`, `rx_par` and `rx_data` are all zero.
- R2: A bit lasts 16 ticks when `dbl_speed` is 0 and 8 ticks when it is 1. The mode, `num_bits` and `par_en` are captured on the tick that takes the first low sample of a start bit, and they hold for the whole frame.
- R3: Samples are numbered from 1 within each bit. The first low start sample is number 1. The level of a bit is the majority of samples 8, 9 and 10 (normal mode) or 4, 5 and 6 (double speed). A single deviating centre sample does not change the bit. Two deviating centre samples decide it.
- R4: A start whose centre vote is high is discarded without any output. A new start needs a high sample followed by a low sample, and a valid frame after a discarded start decodes normally.
- R5: The data bits are received LSB first into `rx_data[0]` upward. Bits above the frame length read 0. A `num_bits` value below 5 counts as 5, and one above 9 counts as 9.
- R6: With `par_en` = 1, one parity bit follows the data, and its voted level appears raw on `rx_par`. With `par_en` = 0, no parity bit is expected and `rx_par` reads 0.
- R7: A stop bit that votes 0 raises `frame_err` together with `rx_valid`. A stop bit that votes 1 leaves `frame_err` at 0.
- R8: `rx_valid` rises for exactly one clock per accepted frame, one clock after the tick of the stop bit's last voting sample. `rx_data` and `rx_par` hold the result during that clock, and `frame_err` is never high without `rx_valid`.
- R9: A falling edge on the sample just after the stop bit's last voting sample starts the next frame: sample 11 in normal mode, sample 7 in double speed.
- R10: Extra stop bits and idle time of any length between frames do not disturb decoding, because timing restarts at each start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, one clock wide |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| rxd | input | 1 | Asynchronous serial line, idle high |
| num_bits | input | 4 | Data bits per frame (5 to 9, clamped) |
| par_en | input | 1 | 1 when a parity bit follows the data |
| rx_data | output | 9 | Received data word, right-aligned |
| rx_valid | output | 1 | One-clock result strobe |
| frame_err | output | 1 | Stop bit voted low, with `rx_valid` |
| rx_par | output | 1 | Raw received parity bit |

## Verification
The frame table covers both speeds, several data lengths (including two out-of-range length codes), and parity on and off. In each frame, a chosen set of centre samples is inverted in every data, parity and stop bit. A single inverted sample must leave the word intact, which separates a vote from a one-point sample. Two inverted samples must flip every bit and cause a frame error, which shows that the vote really uses samples 8 to 10 (or 4 to 6). Directed cases cover:
- a short start pulse that must produce nothing, followed by a clean frame;
- back-to-back frames whose stop bit is cut right after its last voting sample, in both speeds, which shows the early restart;
- a frame with a doubled stop bit, which shows that extra stop time is ignored.

// File: rtl/uvr_pkg.sv
package uvr_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uvr_sync.sv
module uvr_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_LVL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uvr_vote.sv
module uvr_vote
  import uvr_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             active,
  input  logic             samp,
  input  logic [CNT_W-1:0] cur,
  input  logic [CNT_W-1:0] win_lo,
  output logic             vote_last,
  output logic             vote_bit
);
  logic [1:0]       hist;
  logic [CNT_W-1:0] win_hi;
  logic             in_win;

  assign win_hi = win_lo + CNT_W'(2);
  assign in_win = active && (cur >= win_lo) && (cur <= win_hi);

  // the first two window samples are held; the third arrives live
  always_ff @(posedge clk) begin
    if (rst)                 hist <= 2'b00;
    else if (tick && in_win) hist <= {hist[0], samp};
  end

  assign vote_last = tick && active && (cur == win_hi);
  assign vote_bit  = maj3(hist[1], hist[0], samp);
endmodule

// File: rtl/uvr_ctrl.sv
module uvr_ctrl
  import uvr_pkg::*;
#(
  parameter int OSR_NORM = 16,
  parameter int OSR_DBL  = 8,
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 9,
  parameter int CNT_W    = 5,
  parameter int NB_W     = 4,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                samp,
  input  logic                dbl_speed,
  input  logic [NB_W-1:0]     num_bits,
  input  logic                par_en,
  input  logic                vote_last,
  input  logic                vote_bit,
  output logic                active,
  output logic [CNT_W-1:0]    cur,
  output logic [CNT_W-1:0]    win_lo,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                frame_err,
  output logic                rx_par
);
  localparam logic [CNT_W-1:0] OSR_N = CNT_W'(OSR_NORM);
  localparam logic [CNT_W-1:0] OSR_D = CNT_W'(OSR_DBL);

  rx_state_e           state;
  logic [CNT_W-1:0]    phase;
  logic [IDX_W-1:0]    bit_idx;
  logic [IDX_W-1:0]    last_idx;
  logic                mode_q;
  logic                pe_q;
  logic                prev_hi;
  logic [MAX_BITS-1:0] data_q;
  logic                par_q;
  logic [CNT_W-1:0]    osr;

  function automatic logic [IDX_W-1:0] last_of(input logic [NB_W-1:0] n);
    int v;
    v = int'(n);
    if (v < MIN_BITS) v = MIN_BITS;
    if (v > MAX_BITS) v = MAX_BITS;
    return IDX_W'(v - 1);
  endfunction

  assign osr    = mode_q ? OSR_D : OSR_N;
  assign win_lo = osr >> 1;
  assign cur    = phase + CNT_W'(1);
  assign active = (state != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      phase     <= '0;
      bit_idx   <= '0;
      last_idx  <= '0;
      mode_q    <= 1'b0;
      pe_q      <= 1'b0;
      prev_hi   <= 1'b0;
      data_q    <= '0;
      par_q     <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      rx_par    <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      if (tick) begin
        prev_hi <= samp;
        if (state == RX_IDLE) begin
          if (prev_hi && !samp) begin
            state    <= RX_START;
            phase    <= CNT_W'(1);
            mode_q   <= dbl_speed;
            pe_q     <= par_en;
            last_idx <= last_of(num_bits);
            bit_idx  <= '0;
            data_q   <= '0;
            par_q    <= 1'b0;
          end
        end else begin
          phase <= (cur == osr) ? '0 : cur;
          case (state)
            RX_START: begin
              if (vote_last && vote_bit) begin
                state <= RX_IDLE;
                phase <= '0;
              end else if (cur == osr) begin
                state <= RX_DATA;
              end
            end
            RX_DATA: begin
              if (vote_last) data_q[bit_idx] <= vote_bit;
              if (cur == osr) begin
                if (bit_idx == last_idx) state <= pe_q ? RX_PAR : RX_STOP;
                else                     bit_idx <= bit_idx + IDX_W'(1);
              end
            end
            RX_PAR: begin
              if (vote_last) par_q <= vote_bit;
              if (cur == osr) state <= RX_STOP;
            end
            RX_STOP: begin
              if (vote_last) begin
                state     <= RX_IDLE;
                phase     <= '0;
                rx_valid  <= 1'b1;
                frame_err <= !vote_bit;
                rx_data   <= data_q;
                rx_par    <= par_q;
              end
            end
            default: state <= RX_IDLE;
          endcase
        end
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8
  ferr_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> rx_valid);

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> (last_idx + IDX_W'(1))) == '0));

  // R6
  par_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !pe_q) |-> !rx_par);

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= osr);

  // R4
  spike_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_START && vote_last && vote_bit) |=> (state == RX_IDLE && !rx_valid));

  // R9
  early_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_STOP && vote_last) |=> (state == RX_IDLE && rx_valid));
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
  import uvr_pkg::*;
#(
  parameter int OSR_NORM    = 16,
  parameter int OSR_DBL     = 8,
  parameter int MIN_BITS    = 5,
  parameter int MAX_BITS    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         os_tick,
  input  logic                         dbl_speed,
  input  logic                         rxd,
  input  logic [$clog2(MAX_BITS+1)-1:0] num_bits,
  input  logic                         par_en,
  output logic [MAX_BITS-1:0]          rx_data,
  output logic                         rx_valid,
  output logic                         frame_err,
  output logic                         rx_par
);
  localparam int CNT_W = $clog2(OSR_NORM + 1);
  localparam int NB_W  = $clog2(MAX_BITS + 1);
  localparam int IDX_W = $clog2(MAX_BITS);

  logic             samp;
  logic             active;
  logic             vote_last;
  logic             vote_bit;
  logic [CNT_W-1:0] cur;
  logic [CNT_W-1:0] win_lo;

  uvr_sync #(.STAGES(SYNC_STAGES), .RESET_LVL(1'b1)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (samp)
  );

  uvr_vote #(.CNT_W(CNT_W)) i_vote (
    .clk       (clk),
    .rst       (rst),
    .tick      (os_tick),
    .active    (active),
    .samp      (samp),
    .cur       (cur),
    .win_lo    (win_lo),
    .vote_last (vote_last),
    .vote_bit  (vote_bit)
  );

  uvr_ctrl #(
    .OSR_NORM (OSR_NORM),
    .OSR_DBL  (OSR_DBL),
    .MIN_BITS (MIN_BITS),
    .MAX_BITS (MAX_BITS),
    .CNT_W    (CNT_W),
    .NB_W     (NB_W),
    .IDX_W    (IDX_W)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick      (os_tick),
    .samp      (samp),
    .dbl_speed (dbl_speed),
    .num_bits  (num_bits),
    .par_en    (par_en),
    .vote_last (vote_last),
    .vote_bit  (vote_bit),
    .active    (active),
    .cur       (cur),
    .win_lo    (win_lo),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .frame_err (frame_err),
    .rx_par    (rx_par)
  );
endmodule

// File: tb/test_uart_vote_rx.sv
`timescale 1ns/1ps
module test_uart_vote_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 200000;

  typedef struct packed {
    logic       dbl;
    logic [3:0] nb;
    logic       pe;
    logic [8:0] data;
    logic       par;
    logic       stop;
    logic [2:0] mask;
  } vec_t;

  // mask: centre samples (bit0 = first) inverted in data, parity and stop bits
  localparam vec_t VECS [10] = '{
    vec_t'({1'b0, 4'd8,  1'b0, 9'h0A5, 1'b0, 1'b1, 3'b000}),
    vec_t'({1'b0, 4'd8,  1'b1, 9'h03C, 1'b1, 1'b1, 3'b001}),
    vec_t'({1'b0, 4'd5,  1'b0, 9'h1F5, 1'b0, 1'b1, 3'b010}),
    vec_t'({1'b0, 4'd9,  1'b1, 9'h1A3, 1'b0, 1'b1, 3'b100}),
    vec_t'({1'b1, 4'd7,  1'b0, 9'h055, 1'b0, 1'b1, 3'b000}),
    vec_t'({1'b1, 4'd9,  1'b1, 9'h100, 1'b1, 1'b1, 3'b010}),
    vec_t'({1'b0, 4'd8,  1'b0, 9'h0FF, 1'b0, 1'b0, 3'b000}),
    vec_t'({1'b1, 4'd6,  1'b1, 9'h02A, 1'b0, 1'b0, 3'b001}),
    vec_t'({1'b0, 4'd12, 1'b0, 9'h1C3, 1'b0, 1'b1, 3'b000}),
    vec_t'({1'b0, 4'd3,  1'b1, 9'h0B6, 1'b1, 1'b1, 3'b101})
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       dbl_speed = 1'b0;
  logic       rxd = 1'b1;
  logic [3:0] num_bits = 4'd8;
  logic       par_en = 1'b0;
  logic [8:0] rx_data;
  logic       rx_valid;
  logic       frame_err;
  logic       rx_par;

  int tests = 0;
  int fails = 0;
  int cap_cnt = 0;
  int width_err = 0;
  int orphan_err = 0;
  int tick_ctr = 0;
  logic       prev_valid = 1'b0;
  logic [8:0] cap_d [4];
  logic       cap_p [4];
  logic       cap_f [4];

  uart_vote_rx i_uart_vote_rx (
    .clk       (clk),
    .rst       (rst),
    .os_tick   (os_tick),
    .dbl_speed (dbl_speed),
    .rxd       (rxd),
    .num_bits  (num_bits),
    .par_en    (par_en),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .frame_err (frame_err),
    .rx_par    (rx_par)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_ctr = (tick_ctr + 1) % TICK_DIV;
    os_tick  = (tick_ctr == 0);
  end

  // result monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        cap_d[cap_cnt % 4] = rx_data;
        cap_p[cap_cnt % 4] = rx_par;
        cap_f[cap_cnt % 4] = frame_err;
        cap_cnt++;
      end
      if (rx_valid && prev_valid) width_err++;
      if (frame_err && !rx_valid) orphan_err++;
      prev_valid = rx_valid;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (!os_tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic lvl);
    rxd = lvl;
    wait_tick();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) put(1'b1);
  endtask

  task automatic send_bit(input logic b, input int osr, input logic [2:0] mask, input int len);
    for (int s = 1; s <= len; s++) begin
      logic lvl;
      lvl = b;
      for (int j = 0; j < 3; j++)
        if (mask[j] && s == osr/2 + j) lvl = ~b;
      put(lvl);
    end
  endtask

  function automatic int eff_bits(input logic [3:0] nb);
    if (nb < 5) return 5;
    if (nb > 9) return 9;
    return int'(nb);
  endfunction

  task automatic send_frame(input logic dbl, input logic [3:0] nb, input logic pe,
                            input logic [8:0] data, input logic par, input logic stop,
                            input logic [2:0] mask, input int stop_len);
    int osr;
    osr = dbl ? 8 : 16;
    dbl_speed = dbl;
    num_bits  = nb;
    par_en    = pe;
    send_bit(1'b0, osr, 3'b000, osr);
    for (int i = 0; i < eff_bits(nb); i++) send_bit(data[i], osr, mask, osr);
    if (pe) send_bit(par, osr, mask, osr);
    send_bit(stop, osr, mask, (stop_len == 0) ? osr : stop_len);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c0;
    logic [8:0] m;
    logic [8:0] ed;
    logic inv;
    // R1: reset state
    repeat (5) @(negedge clk);
    check("R1 valid in reset", rx_valid, 0);
    check("R1 ferr in reset", frame_err, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 data after reset", rx_data, 0);
    check("R1 par after reset", rx_par, 0);
    idle(4);

    // table of frames
    for (int i = 0; i < 10; i++) begin
      vec_t v;
      v = VECS[i];
      c0 = cap_cnt;
      m = 9'((1 << eff_bits(v.nb)) - 1);
      inv = ($countones(v.mask) >= 2);
      ed = (inv ? ~v.data : v.data) & m;
      send_frame(v.dbl, v.nb, v.pe, v.data, v.par, v.stop, v.mask, 0);
      idle(3);
      check("R8 one strobe per frame", cap_cnt, c0 + 1);
      check(v.dbl ? "R2 dbl-speed data" : (inv ? "R3 two-sample vote data" : "R5 data word"),
            cap_d[c0 % 4], ed);
      check("R6 raw parity", cap_p[c0 % 4], v.pe ? (v.par ^ inv) : 1'b0);
      check("R7 frame error", cap_f[c0 % 4], !(v.stop ^ inv));
    end

    // R4: start spike loses the vote (samples 9,10 high)
    c0 = cap_cnt;
    dbl_speed = 1'b0;
    for (int s = 1; s <= 16; s++) put(s <= 8 ? 1'b0 : 1'b1);
    idle(40);
    check("R4 spike gives no frame", cap_cnt, c0);
    send_frame(1'b0, 4'd8, 1'b0, 9'h05A, 1'b0, 1'b1, 3'b000, 0);
    idle(3);
    check("R4 frame after spike", cap_d[c0 % 4], 9'h05A);

    // R9: stop cut after last voting sample, normal speed
    c0 = cap_cnt;
    send_frame(1'b0, 4'd8, 1'b0, 9'h0C3, 1'b0, 1'b1, 3'b000, 10);
    send_frame(1'b0, 4'd8, 1'b0, 9'h03E, 1'b0, 1'b1, 3'b000, 0);
    idle(3);
    check("R9 normal two frames", cap_cnt, c0 + 2);
    check("R9 normal first", cap_d[c0 % 4], 9'h0C3);
    check("R9 normal second", cap_d[(c0 + 1) % 4], 9'h03E);

    // R9: same in double speed, cut at sample 6
    c0 = cap_cnt;
    send_frame(1'b1, 4'd8, 1'b1, 9'h091, 1'b1, 1'b1, 3'b000, 6);
    send_frame(1'b1, 4'd8, 1'b0, 9'h06E, 1'b0, 1'b1, 3'b000, 0);
    idle(3);
    check("R9 dbl two frames", cap_cnt, c0 + 2);
    check("R9 dbl first", cap_d[c0 % 4], 9'h091);
    check("R9 dbl first parity", cap_p[c0 % 4], 1'b1);
    check("R9 dbl second", cap_d[(c0 + 1) % 4], 9'h06E);

    // R10: doubled stop bit and odd idle gap
    c0 = cap_cnt;
    send_frame(1'b0, 4'd7, 1'b0, 9'h033, 1'b0, 1'b1, 3'b000, 32);
    idle(5);
    send_frame(1'b0, 4'd7, 1'b0, 9'h04C, 1'b0, 1'b1, 3'b000, 0);
    idle(3);
    check("R10 frames after long stop", cap_cnt, c0 + 2);
    check("R10 second word", cap_d[(c0 + 1) % 4], 9'h04C);
    check("R10 no frame error", cap_f[(c0 + 1) % 4], 1'b0);

    check("R8 strobe width", width_err, 0);
    check("R8 ferr without valid", orphan_err, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule